// File: doc/BRIEF.md
# Serial Memory Slave with Page Write and Block Protection

This block is the device end of a serial memory on an SPI bus. A host drives chip select, serial clock and serial data in, and reads serial data out. Each frame opens with a one-byte command. Some commands are followed by a two-byte address sent high byte first. Reads stream bytes from an internal storage array. Writes gather up to one page of bytes into a buffer. Raising chip select after a whole number of data bytes starts a timed internal cycle, and that cycle copies the buffer into the array.

All bus pins are sampled into the system clock domain, which must run several times faster than the serial clock. Both clock polarities are accepted: clock mode 0 (serial clock idles low) and clock mode 3 (serial clock idles high). Data in is taken on rising serial clock edges, and data out changes after falling edges. A status byte holds four fields: a busy flag, a write enable latch and two block-protect bits. The protect bits can lock the upper quarter, the upper half or all of the array. A write-protect pin locks the status byte against writes. A hold pin pauses a transfer in the middle of a byte.

The array has 2^`ADDR_W` bytes. Setting `ADDR_W`=14 gives the full 16K x 8 part. A smaller default keeps elaboration light. Address bits above `ADDR_W` are ignored.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset `so_en` is low, and a status read returns 0x00.
- R2: Command 0x03 followed by a two-byte address returns the stored bytes, most significant bit first, in both clock mode 0 and clock mode 3.
- R3: A read keeps going through consecutive addresses for as long as the clock runs. After the last array byte it wraps to address 0.
- R4: Command 0x02 is accepted only while the enable latch is set. It is followed by an address and 1 to 32 data bytes. The data bytes go to consecutive addresses, and the address wraps inside its own 32-byte page. The array changes only once the internal cycle has completed.
- R5: Command 0x06 sets the write enable latch and command 0x04 clears it. Command 0x02 or 0x01 sent while the latch is clear changes nothing and starts no cycle.
- R6: Command 0x05 returns the status byte: bit 0 is busy, bit 1 is the enable latch, bits 3:2 are the protect setting, and all other bits are 0. Command 0x01 followed by one byte loads bits 3:2 from that byte. This takes effect at the end of the timed cycle, and only if `wp_n` is high when chip select rises.
- R7: Protect setting 00 locks nothing, 01 locks the top quarter of the array, 10 locks the top half and 11 locks all of it. A write to a locked page starts no cycle, leaves the array unchanged and leaves the latch set.
- R8: Once a write cycle starts, status bit 0 reads 1 for `WR_CYC` clocks. During that time every command except 0x05 is ignored. When the cycle ends, the latch is cleared.
- R9: If chip select rises in the middle of a byte during a data write or a status write, no cycle starts and the array is not changed.
- R10: While `hold_n` is low, serial clock edges are ignored and `so_en` is low. When `hold_n` goes high again, the transfer continues at the same bit.
- R11: `so_en` is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Status write lock, active low |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for `so`; the pad is high impedance while it is low |

## Verification
The assertions assume that the pins reach the core through two flop stages. They also assume that `cs_n` and `hold_n` stay steady for at least two clocks around any serial clock edge that counts. The bench holds each serial clock phase for six system clocks. It changes `si`, `hold_n` and `cs_n` only while the serial clock sits at the level it will hold for the next six clocks. It starts a new frame only after chip select has been high for several clocks.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5,
  parameter int WR_CYC = 600
)(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(WR_CYC + 1);

  typedef enum logic [2:0] {S_CMD, S_AH, S_AL, S_WDATA, S_RDATA, S_SR_OUT, S_SR_IN, S_SKIP} st_t;

  logic [1:0] cs_q, sck_q, si_q, hold_q, wp_q;
  logic sck_d, cs_d;
  logic cs_s, sck_s, si_s, hold_s, wp_s;
  logic active, rise, fall, cs_rise;

  st_t st;
  logic [2:0] bitc;
  logic [6:0] sh;
  logic [7:0] ahi, out_sh;
  logic [ADDR_W-1:0] addr;
  logic fresh, is_wr, got, sr_pend, mem_pend, busy, wel;
  logic [1:0] sr_new, bp;
  logic [CW-1:0] cnt;
  logic [PAGE-1:0] pval;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];

  logic [7:0] byte_in, status;
  logic [15:0] a16;
  logic prot, wr_byte, commit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 2'b11; sck_q <= 2'b00; si_q <= 2'b00; hold_q <= 2'b11; wp_q <= 2'b11;
      sck_d <= 1'b0; cs_d <= 1'b1;
    end else begin
      cs_q <= {cs_q[0], cs_n}; sck_q <= {sck_q[0], sck}; si_q <= {si_q[0], si};
      hold_q <= {hold_q[0], hold_n}; wp_q <= {wp_q[0], wp_n};
      sck_d <= sck_q[1]; cs_d <= cs_q[1];
    end

  assign cs_s = cs_q[1];
  assign sck_s = sck_q[1];
  assign si_s = si_q[1];
  assign hold_s = hold_q[1];
  assign wp_s = wp_q[1];
  assign active = !cs_s && hold_s;
  assign rise = active && sck_s && !sck_d;
  assign fall = active && !sck_s && sck_d;
  assign cs_rise = cs_s && !cs_d;

  assign byte_in = {sh, si_s};
  assign a16 = {ahi, byte_in};
  assign status = {4'b0000, bp, wel, busy};
  assign wr_byte = rise && bitc == 3'd7 && st == S_WDATA;
  assign commit = busy && mem_pend && cnt == CW'(WR_CYC - 1);

  always_comb
    case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = addr[ADDR_W-1] && addr[ADDR_W-2];
      2'b10:   prot = addr[ADDR_W-1];
      default: prot = 1'b1;
    endcase

  assign so = out_sh[7];
  assign so_en = active && (st == S_RDATA || st == S_SR_OUT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_CMD; bitc <= '0; sh <= '0; ahi <= '0; addr <= '0; out_sh <= '0;
      fresh <= 1'b0; is_wr <= 1'b0; got <= 1'b0; sr_new <= '0; sr_pend <= 1'b0;
      mem_pend <= 1'b0; busy <= 1'b0; cnt <= '0; wel <= 1'b0; bp <= '0; pval <= '0;
    end else begin
      if (busy) begin
        if (cnt == CW'(WR_CYC - 1)) begin
          busy <= 1'b0; cnt <= '0; wel <= 1'b0; mem_pend <= 1'b0; sr_pend <= 1'b0; pval <= '0;
          if (sr_pend) bp <= sr_new;
        end else cnt <= cnt + 1'b1;
      end
      if (cs_s) begin
        st <= S_CMD; bitc <= '0; fresh <= 1'b0; got <= 1'b0;
        if (cs_rise && bitc == 3'd0 && got && !busy) begin
          if (st == S_WDATA && !prot) begin busy <= 1'b1; mem_pend <= 1'b1; end
          if (st == S_SR_IN && wp_s) begin busy <= 1'b1; sr_pend <= 1'b1; end
        end
      end else if (fall) begin
        if (fresh) fresh <= 1'b0;
        else out_sh <= {out_sh[6:0], 1'b0};
      end else if (rise) begin
        sh <= byte_in[6:0];
        bitc <= bitc + 1'b1;
        if (bitc == 3'd7)
          case (st)
            S_CMD:
              if (busy) begin
                if (byte_in == 8'h05) begin out_sh <= status; fresh <= 1'b1; st <= S_SR_OUT; end
                else st <= S_SKIP;
              end else
                case (byte_in)
                  8'h06: begin wel <= 1'b1; st <= S_SKIP; end
                  8'h04: begin wel <= 1'b0; st <= S_SKIP; end
                  8'h05: begin out_sh <= status; fresh <= 1'b1; st <= S_SR_OUT; end
                  8'h01: st <= wel ? S_SR_IN : S_SKIP;
                  8'h03: begin is_wr <= 1'b0; st <= S_AH; end
                  8'h02: begin is_wr <= 1'b1; st <= wel ? S_AH : S_SKIP; end
                  default: st <= S_SKIP;
                endcase
            S_AH: begin ahi <= byte_in; st <= S_AL; end
            S_AL:
              if (is_wr) begin
                addr <= a16[ADDR_W-1:0]; pval <= '0; st <= S_WDATA;
              end else begin
                out_sh <= mem[a16[ADDR_W-1:0]]; addr <= a16[ADDR_W-1:0] + 1'b1;
                fresh <= 1'b1; st <= S_RDATA;
              end
            S_WDATA: begin
              pval[addr[PAGE_W-1:0]] <= 1'b1;
              addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
              got <= 1'b1;
            end
            S_RDATA: begin out_sh <= mem[addr]; addr <= addr + 1'b1; fresh <= 1'b1; end
            S_SR_OUT: begin out_sh <= status; fresh <= 1'b1; end
            S_SR_IN: begin sr_new <= byte_in[3:2]; got <= 1'b1; end
            default: ;
          endcase
      end
    end

  always_ff @(posedge clk) begin
    if (wr_byte) pbuf[addr[PAGE_W-1:0]] <= byte_in;
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (pval[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic so_en,
  input logic busy,
  input logic wel,
  input logic [1:0] bp
);
  AST_SO_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) so_en |-> !$past(cs_n, 2)); // R11
  AST_SO_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) so_en |-> $past(hold_n, 2)); // R10
  AST_CYCLE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> wel); // R5
  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel); // R8
  AST_BP_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n) !$stable(bp) |-> $fell(busy)); // R6
endmodule

bind spi_eeprom_slave spi_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
  .so_en(so_en), .busy(busy), .wel(wel), .bp(bp)
);

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SH = 6;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1, wp_n = 1;
  logic so, so_en;
  int checks = 0, fails = 0;

  logic [7:0] tx [64];
  logic [7:0] rx [64];
  logic [7:0] mm [DEPTH];
  logic known [DEPTH];
  logic m_wel = 0;
  logic [1:0] m_bp = 0;

  spi_eeprom_slave dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic locked(input int a, input logic [1:0] b);
    case (b)
      2'b00: return 1'b0;
      2'b01: return a >= DEPTH * 3 / 4;
      2'b10: return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic frame(input int n, input int mode, input int extra, input int hold_byte);
    sck = (mode != 0); wt(SH);
    cs_n = 0; wt(SH);
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        sck = 0; si = tx[b][i]; wt(SH);
        rx[b][i] = so; sck = 1; wt(SH);
        if (b == hold_byte && i == 4) begin
          hold_n = 0; wt(SH);
          chk(so_en == 0, "R10 so_en during hold", so_en, 0);
          for (int k = 0; k < 2; k++) begin
            sck = 0; si = ~si; wt(SH); sck = 1; wt(SH);
          end
          chk(so_en == 0, "R10 so_en after held clocks", so_en, 0);
          hold_n = 1; wt(SH);
        end
      end
    for (int i = 0; i < extra; i++) begin
      sck = 0; si = 1; wt(SH); sck = 1; wt(SH);
    end
    if (mode == 0) sck = 0;
    wt(SH);
    cs_n = 1; wt(2 * SH);
  endtask

  task automatic cmd1(input logic [7:0] op);
    tx[0] = op; frame(1, 0, 0, -1);
  endtask

  task automatic rdsr(output logic [7:0] v);
    tx[0] = 8'h05; tx[1] = 8'h00; frame(2, 0, 0, -1); v = rx[1];
  endtask

  function automatic logic [7:0] exp_sr(input logic b);
    return {4'b0, m_bp, m_wel, b};
  endfunction

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 40; k++) begin
      rdsr(v);
      if (!v[0]) break;
    end
  endtask

  task automatic after_start(input logic started, input string req);
    logic [7:0] v;
    rdsr(v);
    chk(v == exp_sr(started), req, v, exp_sr(started));
    if (started) begin
      m_wel = 0;
      wait_idle();
    end
  endtask

  // caller fills tx[3..3+n-1]
  task automatic mwrite(input int a, input int n, input int mode, input int extra, input string req);
    logic started;
    tx[0] = 8'h02; tx[1] = 8'(a >> 8); tx[2] = 8'(a);
    frame(3 + n, mode, extra, -1);
    started = m_wel && !locked(a, m_bp) && extra == 0;
    if (started)
      for (int i = 0; i < n; i++) begin
        int t = (a & ~31) | ((a + i) & 31);
        mm[t] = tx[3 + i]; known[t] = 1;
      end
    after_start(started, req);
  endtask

  task automatic mread(input int a, input int n, input int mode, input int hold_byte, input string req);
    tx[0] = 8'h03; tx[1] = 8'(a >> 8); tx[2] = 8'(a);
    for (int i = 0; i < n; i++) tx[3 + i] = 8'h00;
    frame(3 + n, mode, 0, hold_byte);
    for (int i = 0; i < n; i++) begin
      int t = (a + i) % DEPTH;
      if (known[t]) chk(rx[3 + i] == mm[t], req, rx[3 + i], mm[t]);
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) tx[3 + i] = 8'($urandom);
  endtask

  task automatic wrsr(input logic [7:0] v, input string req);
    logic started;
    tx[0] = 8'h01; tx[1] = v; frame(2, 0, 0, -1);
    started = m_wel && wp_n;
    after_start(started, req);
    if (started) m_bp = v[3:2];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    wt(5); rst_n = 1; wt(5);
    chk(so_en == 0, "R1 so_en after reset", so_en, 0);
    chk(so_en == 0, "R11 so_en with cs high", so_en, 0);
    rdsr(v); chk(v == 8'h00, "R1 status after reset", v, 0);

    cmd1(8'h06); m_wel = 1;
    rdsr(v); chk(v == 8'h02, "R5 WREN sets latch", v, 2);
    cmd1(8'h04); m_wel = 0;
    rdsr(v); chk(v == 8'h00, "R5 WRDI clears latch", v, 0);

    // R8: full page, WREN during busy ignored, latch cleared at end
    cmd1(8'h06); m_wel = 1;
    fill(32);
    tx[0] = 8'h02; tx[1] = 0; tx[2] = 0;
    frame(35, 0, 0, -1);
    for (int i = 0; i < 32; i++) begin mm[i] = tx[3 + i]; known[i] = 1; end
    rdsr(v); chk(v == 8'h03, "R8 busy after write", v, 3);
    cmd1(8'h06);
    m_wel = 0; wait_idle();
    rdsr(v); chk(v == 8'h00, "R8 latch cleared, WREN ignored while busy", v, 0);
    mread(0, 32, 3, -1, "R2 R4 mode 3 page read");
    mread(0, 32, 0, -1, "R2 mode 0 page read");

    // last page, wrap read
    cmd1(8'h06); m_wel = 1; fill(32);
    mwrite(DEPTH - 32, 32, 3, 0, "R4 last page write");
    mread(DEPTH - 3, 6, 0, -1, "R3 wrap to zero");

    // page wrap inside page
    cmd1(8'h06); m_wel = 1; fill(4);
    mwrite(12'h040 + 30, 4, 0, 0, "R4 in-page wrap");
    mread(12'h040 + 28, 8, 0, -1, "R4 in-page wrap readback");

    // no WEL
    fill(2);
    mwrite(12'h040 + 1, 2, 0, 0, "R5 write without latch");
    mread(12'h040, 4, 3, -1, "R5 unchanged after rejected write");

    // partial byte
    cmd1(8'h06); m_wel = 1; fill(1);
    mwrite(12'h040, 1, 0, 3, "R9 partial byte keeps latch, no cycle");
    mread(12'h040, 2, 0, -1, "R9 array unchanged");
    tx[0] = 8'h01; tx[1] = 8'h0C; frame(2, 0, 3, -1);
    rdsr(v); chk(v == 8'h02, "R9 partial status byte ignored", v, 2);
    cmd1(8'h04); m_wel = 0;

    // half page, then random traffic
    cmd1(8'h06); m_wel = 1; fill(32);
    mwrite(DEPTH / 2, 32, 0, 0, "R4 half page write");
    for (int it = 0; it < 12; it++) begin
      int a = $urandom % (DEPTH / 2);
      int n = 1 + $urandom % 32;
      int md = ($urandom % 2) * 3;
      cmd1(8'h06); m_wel = 1; fill(n);
      mwrite(a, n, md, 0, "R4 random write");
      mread(a & ~31, 32, 3 - md, -1, "R2 random readback");
    end

    // HOLD
    mread(0, 8, 0, 4, "R10 read resumes after hold mode 0");
    mread(0, 8, 3, 5, "R10 read resumes after hold mode 3");

    // protection
    cmd1(8'h06); m_wel = 1; wrsr(8'h04, "R6 WRSR starts cycle");
    rdsr(v); chk(v == 8'h04, "R6 bp=01 stored", v, 4);
    cmd1(8'h06); m_wel = 1; fill(4);
    mwrite(DEPTH - 32, 4, 0, 0, "R7 quarter locked");
    mread(DEPTH - 32, 4, 0, -1, "R7 quarter unchanged");
    fill(4);
    mwrite(DEPTH / 2, 4, 0, 0, "R7 below quarter writable");
    mread(DEPTH / 2, 4, 0, -1, "R7 below quarter readback");
    cmd1(8'h06); m_wel = 1; wrsr(8'h08, "R6 WRSR bp=10");
    cmd1(8'h06); m_wel = 1; fill(4);
    mwrite(DEPTH / 2, 4, 3, 0, "R7 half locked");
    mread(DEPTH / 2, 4, 0, -1, "R7 half unchanged");
    fill(4);
    mwrite(0, 4, 0, 0, "R7 lower half writable");
    mread(0, 4, 0, -1, "R7 lower half readback");
    cmd1(8'h06); m_wel = 1; wrsr(8'h0C, "R6 WRSR bp=11");
    cmd1(8'h06); m_wel = 1; fill(4);
    mwrite(0, 4, 0, 0, "R7 all locked");
    mread(0, 4, 3, -1, "R7 all unchanged");

    // WP pin
    wp_n = 0;
    wrsr(8'h00, "R6 WRSR rejected under wp_n low");
    rdsr(v); chk(v == 8'h0E, "R6 bp kept under wp_n low", v, 8'h0E);
    wp_n = 1;
    wrsr(8'h00, "R6 WRSR accepted with wp_n high");
    rdsr(v); chk(v == 8'h00, "R6 bp cleared", v, 0);

    chk(so_en == 0, "R11 so_en idle at end", so_en, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule